// File: doc/BRIEF.md
# Packed Colour Lookup Table with Channel Widening

This block holds a 256-entry colour lookup table for a display pipeline. The register bus sees the table as 128 words of 32 bits inside a fixed byte window. Each bus word carries two 16-bit colour entries. Every entry stores three 5-bit channels and one spare bit that the colour output ignores.

A separate lookup port takes an 8-bit pixel index and returns a 24-bit colour one cycle later. Each 5-bit channel is widened to 8 bits by appending three zero bits. An order input can swap the outer two bytes of the result, which gives blue-first output. Bus reads return the stored 32-bit word exactly as it was written, including the spare bits.

Top module: `clut_packed`

## Requirements
- R1: After reset every table word reads as zero, `rd_valid` and `px_valid_o` are low, and `rd_data` and `px_rgb` are zero.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1) to a byte offset from 0x200 to 0x3FF stores `bus_wdata` in word (offset-0x200)>>2. Address bits [1:0] do not select the word. Bits [15:0] of word n are entry 2n, and bits [31:16] are entry 2n+1.
- R3: A bus read (`bus_sel`=1, `bus_wr`=0) inside the window raises `rd_valid` in the next cycle, with `rd_data` equal to the full 32-bit word last written there. `rd_data` holds its value while no read is made.
- R4: Within an entry, bits [4:0] are red, [9:5] are green and [14:10] are blue. With `px_bgr`=0 the output places red in `px_rgb[23:16]`, green in [15:8] and blue in [7:0].
- R5: Bit 15 of an entry has no effect on `px_rgb`.
- R6: Each 5-bit channel c appears on the output as c shifted left by three places, so the low three bits of every output byte are zero.
- R7: A lookup presented with `px_valid`=1 produces `px_valid_o`=1 and its colour in the next cycle. `px_rgb` holds its value while no lookup is made.
- R8: A lookup made in the same cycle as a write to its word returns the old entry. A lookup made in any later cycle returns the new entry.
- R9: With `px_bgr`=1 at the time of the lookup, blue appears in `px_rgb[23:16]` and red in [7:0]. Green stays in [15:8].
- R10: A bus write outside the window changes no table word. A bus read outside the window returns zero with `rd_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | 32 | Read data |
| px_valid | input | 1 | Lookup request |
| px_index | input | 8 | Pixel colour index |
| px_bgr | input | 1 | Swap the red and blue output bytes |
| px_valid_o | output | 1 | Lookup result valid |
| px_rgb | output | 24 | Widened colour |

## Verification
The bench builds the block with its default parameters: 128 words, a 12-bit byte address and a window base of 0x200. These values put every table word, both edges of the window and the addresses just outside it within reach in a short run. The bench compares against a behavioural table model on every cycle. It uses patterned, extreme and pseudo-random entries, both output orders, and a long stretch of random bus and lookup traffic. In that traffic, writes and lookups to the same word often fall in the same cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CH_IN   = 5;
  localparam int CH_OUT  = 8;
  localparam int ENTRY_W = 16;
  localparam int PER_WORD = 2;
  localparam int WORD_W  = ENTRY_W * PER_WORD;
  localparam int RGB_W   = 3 * CH_OUT;

  typedef struct packed {
    logic [CH_OUT-1:0] hi;
    logic [CH_OUT-1:0] mid;
    logic [CH_OUT-1:0] lo;
  } rgb_t;

  // widen one channel: append zeros below
  function automatic logic [CH_OUT-1:0] widen(input logic [CH_IN-1:0] c);
    return {c, {(CH_OUT-CH_IN){1'b0}}};
  endfunction

  // pick channel k (0 red, 1 green, 2 blue) from an entry
  function automatic logic [CH_IN-1:0] chan(input logic [ENTRY_W-1:0] e,
                                            input int unsigned k);
    return e[k*CH_IN +: CH_IN];
  endfunction

  // full entry to output colour; the top bit of the entry is never read
  function automatic rgb_t to_rgb(input logic [ENTRY_W-1:0] e, input logic swap);
    rgb_t o;
    o.mid = widen(chan(e, 1));
    o.hi  = swap ? widen(chan(e, 2)) : widen(chan(e, 0));
    o.lo  = swap ? widen(chan(e, 0)) : widen(chan(e, 2));
    return o;
  endfunction
endpackage

// File: rtl/clut_addr_dec.sv
module clut_addr_dec #(
  parameter int ADDR_W = 12,
  parameter int WORDS  = 128,
  // base must be a multiple of the window span
  parameter logic [ADDR_W-1:0] BASE = 'h200,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              wr_en,
  output logic              rd_en,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] LIM = {1'b0, BASE} + (ADDR_W+1)'(WORDS*4);

  always_comb begin
    hit   = ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < LIM);
    wr_en = sel && wr && hit;
    rd_en = sel && !wr;
    idx   = addr[IDX_W+1:2];
  end
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  output logic [WORD_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [WORD_W-1:0] rdata_b
);
  logic [WORD_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel_w;
    assign sel_w = we && (widx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n)     words[w] <= '0;
      else if (sel_w) words[w] <= wdata;
    end
    // R2: a selected write lands in exactly this word
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx == IDX_W'(w)) |=> words[w] == $past(wdata));
  end

  assign rdata_a = words[ridx_a];
  assign rdata_b = words[ridx_b];
endmodule

// File: rtl/clut_lookup.sv
module clut_lookup
  import clut_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              px_valid,
  input  logic [IDX_W:0]    px_index,
  input  logic              px_bgr,
  output logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_in,
  output logic              valid_o,
  output logic [RGB_W-1:0]  rgb_o
);
  logic [ENTRY_W-1:0] entry;
  rgb_t               colour;

  assign word_idx = px_index[IDX_W:1];
  assign entry    = px_index[0] ? word_in[WORD_W-1:ENTRY_W] : word_in[ENTRY_W-1:0];
  assign colour   = to_rgb(entry, px_bgr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      rgb_o   <= '0;
    end else begin
      valid_o <= px_valid;
      if (px_valid) rgb_o <= colour;
    end
  end

  // R7: one cycle from request to result
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> valid_o);
  // R7: colour holds while idle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid |=> $stable(rgb_o));
  // R6: zero fill below every widened channel
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (rgb_o[2:0] == 3'b0 && rgb_o[10:8] == 3'b0 && rgb_o[18:16] == 3'b0));
endmodule

// File: rtl/clut_packed.sv
module clut_packed
  import clut_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORDS  = 128,
  parameter logic [ADDR_W-1:0] BASE = 'h200,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              px_valid,
  input  logic [IDX_W:0]    px_index,
  input  logic              px_bgr,
  output logic              px_valid_o,
  output logic [RGB_W-1:0]  px_rgb
);
  logic              hit, st_we, rd_en;
  logic [IDX_W-1:0]  bus_idx, lk_idx;
  logic [WORD_W-1:0] bus_word, lk_word;

  clut_addr_dec #(.ADDR_W(ADDR_W), .WORDS(WORDS), .BASE(BASE)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .hit(hit), .wr_en(st_we), .rd_en(rd_en), .idx(bus_idx));

  clut_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .widx(bus_idx), .wdata(bus_wdata),
    .ridx_a(bus_idx), .rdata_a(bus_word), .ridx_b(lk_idx), .rdata_b(lk_word));

  clut_lookup #(.WORDS(WORDS)) u_look (
    .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_index(px_index),
    .px_bgr(px_bgr), .word_idx(lk_idx), .word_in(lk_word),
    .valid_o(px_valid_o), .rgb_o(px_rgb));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= hit ? bus_word : '0;
    end
  end

  // R3: read answers in the next cycle
  a_r3_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> rd_valid);
  // R10: writes below the window never reach storage
  a_r10_low_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr < BASE) |-> !st_we);
  // R10: out-of-window read returns zero
  a_r10_outside_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr < BASE) |=> rd_data == '0);
endmodule

// File: tb/clut_packed_tb.sv
module clut_packed_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        px_valid = 1'b0;
  logic [7:0]  px_index = '0;
  logic        px_bgr = 1'b0;
  logic        px_valid_o;
  logic [23:0] px_rgb;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] ref_mem [128];
  logic        e_pv, e_rv;
  logic [23:0] e_px;
  logic [31:0] e_rd;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  clut_packed u_dut (.*);

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual cycle %0d expected under 100000", cyc);
      report();
    end
  end

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endfunction

  function automatic logic [23:0] colour(input logic [15:0] e, input logic swap);
    int r, g, b;
    r = (e % 32) * 8;
    g = ((e / 32) % 32) * 8;
    b = ((e / 1024) % 32) * 8;
    return swap ? {b[7:0], g[7:0], r[7:0]} : {r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    int a;
    logic [15:0] e;
    @(posedge clk);
    a = int'(bus_addr);
    e_pv = px_valid;
    if (px_valid) begin
      e = px_index[0] ? ref_mem[px_index/2][31:16] : ref_mem[px_index/2][15:0];
      e_px = colour(e, px_bgr);
    end
    e_rv = bus_sel && !bus_wr;
    if (e_rv) e_rd = (a >= 512 && a < 1024) ? ref_mem[(a-512)/4] : 32'h0;
    if (bus_sel && bus_wr && a >= 512 && a < 1024) ref_mem[(a-512)/4] = bus_wdata;
    @(negedge clk);
    check({tag, " px_valid_o"}, {31'b0, px_valid_o}, {31'b0, e_pv});
    check({tag, " px_rgb"}, {8'b0, px_rgb}, {8'b0, e_px});
    check({tag, " rd_valid"}, {31'b0, rd_valid}, {31'b0, e_rv});
    check({tag, " rd_data"}, rd_data, e_rd);
  endtask

  task automatic idle();
    bus_sel = 1'b0; bus_wr = 1'b0; px_valid = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [31:0] d, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(addr); bus_wdata = d;
    tick(tag); idle();
  endtask

  task automatic rd(input int addr, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'(addr);
    tick(tag); idle();
  endtask

  task automatic look(input int idx, input logic swap, input string tag);
    px_valid = 1'b1; px_index = 8'(idx); px_bgr = swap;
    tick(tag); idle();
  endtask

  initial begin
    logic [23:0] p0;
    for (int i = 0; i < 128; i++) ref_mem[i] = '0;
    e_pv = 0; e_rv = 0; e_px = '0; e_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    check("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 px_valid_o", {31'b0, px_valid_o}, 32'h0);
    check("R1 px_rgb", {8'b0, px_rgb}, 32'h0);
    rd(12'h200, "R1"); rd(12'h3FC, "R1");
    look(0, 0, "R1"); look(255, 1, "R1");

    // R2 fill every word, R3 read back raw
    for (int w = 0; w < 128; w++) wr(512 + 4*w, rnd(), "R2");
    for (int w = 0; w < 128; w++) rd(512 + 4*w, "R3");
    rd(12'h3FF, "R2"); rd(12'h201, "R2");
    wr(12'h206, 32'hA5A5_5A5A, "R2");
    rd(12'h204, "R2");
    check("R2 low bits ignored", rd_data, 32'hA5A5_5A5A);

    // R4 normal order, R9 swapped order
    for (int i = 0; i < 256; i++) look(i, 0, "R4");
    for (int i = 0; i < 256; i++) look(i, 1, "R9");

    // R6: red=1, green=0, blue=31 in entry 6; green=31 only in entry 7
    wr(12'h20C, 32'h03E0_7C01, "R6");
    look(6, 0, "R6");
    check("R6 widened", {8'b0, px_rgb}, 32'h0008_00F8);
    look(7, 1, "R6");
    check("R6 green", {8'b0, px_rgb}, 32'h0000_F800);
    look(6, 1, "R9");
    check("R9 swapped", {8'b0, px_rgb}, 32'h00F8_0008);

    // R5: spare bit toggled, colour unchanged
    wr(12'h214, 32'h1234_4321, "R5");
    look(10, 0, "R5"); p0 = px_rgb;
    wr(12'h214, 32'h9234_C321, "R5");
    look(10, 0, "R5");
    check("R5 spare bit", {8'b0, px_rgb}, {8'b0, p0});
    rd(12'h214, "R3");
    check("R3 raw word", rd_data, 32'h9234_C321);

    // R7: result one cycle after request, then held
    look(11, 0, "R7");
    check("R7 valid", {31'b0, px_valid_o}, 32'h1);
    tick("R7");
    check("R7 drop", {31'b0, px_valid_o}, 32'h0);

    // R8: same-cycle write and lookup sees old, next cycle sees new
    wr(12'h224, 32'h0000_0000, "R8");
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h224; bus_wdata = 32'h7FFF_7FFF;
    px_valid = 1; px_index = 8'd18; px_bgr = 0;
    tick("R8"); idle();
    check("R8 old", {8'b0, px_rgb}, 32'h0);
    look(18, 0, "R8");
    check("R8 new", {8'b0, px_rgb}, 32'h00F8_F8F8);

    // R10: writes outside the window are dropped
    wr(12'h1FC, 32'hDEAD_BEEF, "R10"); wr(12'h400, 32'hDEAD_BEEF, "R10");
    wr(12'h000, 32'hDEAD_BEEF, "R10"); wr(12'hFFC, 32'hDEAD_BEEF, "R10");
    rd(12'h1FC, "R10");
    check("R10 outside read", rd_data, 32'h0);
    check("R10 outside valid", {31'b0, rd_valid}, 32'h1);
    rd(12'h400, "R10");
    for (int w = 0; w < 128; w++) rd(512 + 4*w, "R10");

    // R8: mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = rnd();
      bus_sel = r[0]; bus_wr = r[1];
      bus_addr = 12'h100 + 12'(r[13:4] % 1024);
      if (r[2]) bus_addr = 12'h200 + {5'b0, r[20:14], 2'b0};
      bus_wdata = rnd();
      px_valid = r[3]; px_bgr = r[21];
      px_index = r[22] ? {r[20:14], r[23]} : r[31:24];
      tick("R8");
    end
    idle();
    tick("R7");
    report();
  end
endmodule